// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block sets the bit timing for a serial transmitter. It does not divide the clock by an integer. It keeps a 20-bit phase accumulator, and on each clock the accumulator gains a 16-bit step value taken from the control word. Each carry out of the accumulator is one bit period. The average bit rate is therefore step × f_clk / 2^20, and the step can place that rate anywhere in a fine grid.

A character-complete strobe rises on every tenth bit period. It arrives together with that tenth bit strobe, so a serialiser can use it to load the next frame. The control word is written through a single-cycle write strobe. A write loads the step value and the transmit-enable flag, and the timing starts again from zero phase. This lets a new rate apply from the very next clock.

The sequencing is a three-state machine:
- IDLE: no progress. The machine sits here while transmission is disabled or the step is zero.
- RUN: accumulating, with bits zero to eight of the character still to be completed.
- LAST: accumulating, with the final bit of the character in progress.

It has these transitions:
- load_go: any state to RUN, on a write with enable set and a non-zero step.
- load_stop: any state to IDLE, on a write that disables transmission or gives a zero step.
- enter_last: RUN to LAST, on the carry that completes the ninth bit.
- char_done: LAST to RUN, on the carry that completes the tenth bit, which raises the character strobe.

Top module: `nco_baud_tick`

## Requirements
- R1: After reset, both strobes are low and the machine is in IDLE. No strobe appears until a control write enables timing.
- R2: The step value is control word bits 31:16. On every clock in RUN or LAST, the 20-bit accumulator adds the step. When that add carries out of bit 19, bit_tick_o is high for the following cycle. A step of 0x8000 therefore gives exactly one bit tick per 32 clocks.
- R3: bit_tick_o is never high for two consecutive cycles.
- R4: char_tick_o is high only in a cycle where bit_tick_o is also high. It marks every tenth bit tick counted since the last control write.
- R5: The transmit-enable flag is control word bit 0. While it is clear, the accumulator does not advance and neither strobe is raised.
- R6: A step value of zero with transmission enabled produces no strobes.
- R7: Every control write clears the accumulator and the bit count, and both strobes are low in the cycle after the write. The new step governs the adds from the next clock onward, so a step of S yields its first tick ceil(2^20/S) adds after the write.
- R8: Control word bit 1 (receive enable) and every bit other than 0 and 31:16 have no effect on the strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_we_i | input | 1 | Single-cycle control write strobe |
| ctrl_wdata_i | input | 32 | Control word: step in 31:16, transmit enable in bit 0 |
| bit_tick_o | output | 1 | One-cycle strobe per completed bit period |
| char_tick_o | output | 1 | One-cycle strobe when the tenth bit of a character completes |

## Verification
The bench uses the default parameters: a 20-bit accumulator, a 16-bit step and ten-bit characters. With a step close to 0xFFFF, a bit period lasts about sixteen clocks, so dozens of full characters and many character wraps fit into a few thousand cycles. A step of 0x8000 makes the carries fall on exact multiples of 32 clocks, which pins down the tick count and the restart latency to the cycle. A step of 0x5555 leaves a fractional remainder in the accumulator, which exercises irregular tick spacing against the behavioural model.

// File: rtl/nco_tick_pkg.sv
package nco_tick_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_LAST = 2'd2
    } tick_state_e;

endpackage

// File: rtl/nco_ctrl_reg.sv
module nco_ctrl_reg #(
    parameter int WORD_W  = 32,
    parameter int NCO_W   = 16,
    parameter int NCO_LSB = 16,
    parameter int EN_BIT  = 0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [NCO_W-1:0]  nco_q_o,
    output logic              tx_en_q_o,
    output logic              load_o,
    output logic              load_run_o
);

    logic [NCO_W-1:0] nco_field;
    logic             en_field;

    assign nco_field  = wdata_i[NCO_LSB +: NCO_W];
    assign en_field   = wdata_i[EN_BIT];
    assign load_o     = we_i;
    assign load_run_o = en_field && (nco_field != '0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            nco_q_o   <= '0;
            tx_en_q_o <= 1'b0;
        end else if (we_i) begin
            nco_q_o   <= nco_field;
            tx_en_q_o <= en_field;
        end
    end

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
    parameter int ACC_W = 20,
    parameter int NCO_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clear_i,
    input  logic             advance_i,
    input  logic [NCO_W-1:0] step_i,
    output logic             carry_o
);

    localparam int PAD_W = ACC_W - NCO_W;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   sum;

    assign sum     = {1'b0, acc_q} + {1'b0, {PAD_W{1'b0}}, step_i};
    assign carry_o = advance_i && !clear_i && sum[ACC_W];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            acc_q <= '0;
        end else if (clear_i) begin
            acc_q <= '0;
        end else if (advance_i) begin
            acc_q <= sum[ACC_W-1:0];
        end
    end

endmodule

// File: rtl/nco_char_fsm.sv
module nco_char_fsm
    import nco_tick_pkg::*;
#(
    parameter int CHAR_BITS = 10
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic load_i,
    input  logic load_run_i,
    input  logic carry_i,
    output logic advance_o,
    output logic bit_tick_o,
    output logic char_tick_o
);

    localparam int CNT_W = $clog2(CHAR_BITS);
    localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(CHAR_BITS - 2);

    tick_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // Next-state and bit-count logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (load_i) begin
            state_d = load_run_i ? ST_RUN : ST_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_RUN: begin
                    if (carry_i) begin
                        cnt_d = cnt_q + 1'b1;
                        if (cnt_q == PRE_LAST) begin
                            state_d = ST_LAST;
                        end
                    end
                end
                ST_LAST: begin
                    if (carry_i) begin
                        cnt_d   = '0;
                        state_d = ST_RUN;
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign advance_o = (state_q != ST_IDLE);

    // Output strobes
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            bit_tick_o  <= 1'b0;
            char_tick_o <= 1'b0;
        end else if (load_i) begin
            bit_tick_o  <= 1'b0;
            char_tick_o <= 1'b0;
        end else begin
            bit_tick_o  <= carry_i && (state_q != ST_IDLE);
            char_tick_o <= carry_i && (state_q == ST_LAST);
        end
    end

endmodule

// File: rtl/nco_baud_tick.sv
module nco_baud_tick #(
    parameter int WORD_W    = 32,
    parameter int NCO_W     = 16,
    parameter int NCO_LSB   = 16,
    parameter int EN_BIT    = 0,
    parameter int ACC_W     = 20,
    parameter int CHAR_BITS = 10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ctrl_we_i,
    input  logic [WORD_W-1:0] ctrl_wdata_i,
    output logic              bit_tick_o,
    output logic              char_tick_o
);

    logic [NCO_W-1:0] nco_q;
    logic             tx_en_q;
    logic             load;
    logic             load_run;
    logic             advance;
    logic             carry;

    nco_ctrl_reg #(
        .WORD_W (WORD_W),
        .NCO_W  (NCO_W),
        .NCO_LSB(NCO_LSB),
        .EN_BIT (EN_BIT)
    ) u_ctrl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .we_i      (ctrl_we_i),
        .wdata_i   (ctrl_wdata_i),
        .nco_q_o   (nco_q),
        .tx_en_q_o (tx_en_q),
        .load_o    (load),
        .load_run_o(load_run)
    );

    nco_phase_acc #(
        .ACC_W(ACC_W),
        .NCO_W(NCO_W)
    ) u_acc (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clear_i  (load),
        .advance_i(advance),
        .step_i   (nco_q),
        .carry_o  (carry)
    );

    nco_char_fsm #(
        .CHAR_BITS(CHAR_BITS)
    ) u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (load),
        .load_run_i (load_run),
        .carry_i    (carry),
        .advance_o  (advance),
        .bit_tick_o (bit_tick_o),
        .char_tick_o(char_tick_o)
    );

endmodule

// File: rtl/nco_baud_tick_chk.sv
module nco_baud_tick_chk #(
    parameter int NCO_W     = 16,
    parameter int CHAR_BITS = 10
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             ctrl_we_i,
    input logic             tx_en_i,
    input logic [NCO_W-1:0] nco_i,
    input logic             bit_tick_i,
    input logic             char_tick_i
);

    localparam int CW = $clog2(CHAR_BITS + 1);

    logic [CW-1:0] seen_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seen_q <= '0;
        end else if (ctrl_we_i) begin
            seen_q <= '0;
        end else if (char_tick_i) begin
            seen_q <= '0;
        end else if (bit_tick_i) begin
            seen_q <= seen_q + 1'b1;
        end
    end

    assert_tick_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bit_tick_i |=> !bit_tick_i);

    assert_char_on_bit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        char_tick_i |-> bit_tick_i);

    assert_char_tenth_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        char_tick_i |-> (seen_q == CW'(CHAR_BITS - 1)));

    assert_no_early_char_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bit_tick_i && !char_tick_i) |-> (seen_q < CW'(CHAR_BITS - 1)));

    assert_quiet_disabled_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tx_en_i |=> !bit_tick_i);

    assert_quiet_zero_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (nco_i == '0) |=> !bit_tick_i);

    assert_write_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctrl_we_i |=> (!bit_tick_i && !char_tick_i));

endmodule

bind nco_baud_tick nco_baud_tick_chk #(
    .NCO_W    (NCO_W),
    .CHAR_BITS(CHAR_BITS)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_we_i  (ctrl_we_i),
    .tx_en_i    (tx_en_q),
    .nco_i      (nco_q),
    .bit_tick_i (bit_tick_o),
    .char_tick_i(char_tick_o)
);

// File: tb/nco_baud_tick_bench.sv
module nco_baud_tick_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ACC_MOD    = 1 << 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic        bit_tick;
    logic        char_tick;

    int total = 0;
    int bad = 0;
    int tick_cnt = 0;
    int char_cnt = 0;
    bit done = 1'b0;
    string tag = "R1";

    // behavioural reference state
    int m_acc = 0;
    int m_cnt = 0;
    int m_nco = 0;
    bit m_en = 1'b0;
    bit exp_bit = 1'b0;
    bit exp_char = 1'b0;

    nco_baud_tick u_nco_baud_tick (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .ctrl_we_i   (we),
        .ctrl_wdata_i(wdata),
        .bit_tick_o  (bit_tick),
        .char_tick_o (char_tick)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_acc = 0; m_cnt = 0; m_nco = 0; m_en = 1'b0;
            exp_bit = 1'b0; exp_char = 1'b0;
        end else if (we) begin
            m_nco = int'(wdata[31:16]);
            m_en  = wdata[0];
            m_acc = 0; m_cnt = 0;
            exp_bit = 1'b0; exp_char = 1'b0;
        end else if (m_en && m_nco != 0) begin
            m_acc = m_acc + m_nco;
            exp_bit = (m_acc >= ACC_MOD);
            exp_char = 1'b0;
            if (exp_bit) begin
                m_acc = m_acc - ACC_MOD;
                m_cnt = m_cnt + 1;
                if (m_cnt == 10) begin
                    m_cnt = 0;
                    exp_char = 1'b1;
                end
            end
        end else begin
            exp_bit = 1'b0; exp_char = 1'b0;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            total++;
            if (bit_tick !== exp_bit) begin
                bad++;
                $display("FAIL %s bit_tick actual=%b expected=%b at %0t", tag, bit_tick, exp_bit, $time);
            end
            total++;
            if (char_tick !== exp_char) begin
                bad++;
                $display("FAIL %s char_tick actual=%b expected=%b at %0t", tag, char_tick, exp_char, $time);
            end
            if (bit_tick === 1'b1) tick_cnt++;
            if (char_tick === 1'b1) char_cnt++;
        end
    end

    task automatic write_ctrl(input logic [31:0] w);
        @(negedge clk);
        we = 1'b1;
        wdata = w;
        @(negedge clk);
        we = 1'b0;
        tick_cnt = 0;
        char_cnt = 0;
    endtask

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state and no strobes before any write
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        tick_cnt = 0; char_cnt = 0;
        repeat (40) @(negedge clk);
        check_eq("R1", "ticks before write", tick_cnt, 0);

        // R2: step 0x8000 -> one tick per 32 clocks, ten ticks and one char in 330
        tag = "R2";
        write_ctrl({16'h8000, 16'h0001});
        repeat (330) @(negedge clk);
        check_eq("R2", "bit ticks in 330 clocks", tick_cnt, 10);
        check_eq("R4", "char ticks in 330 clocks", char_cnt, 1);

        // R4: fast step, many characters
        tag = "R4";
        write_ctrl({16'hFFFF, 16'h0001});
        repeat (1700) @(negedge clk);
        check_eq("R4", "char per ten bits", char_cnt, tick_cnt / 10);

        // R8: fractional step with receive enable and stray bits set
        tag = "R8";
        write_ctrl({16'h5555, 16'h00FB});
        repeat (2000) @(negedge clk);
        check_eq("R8", "ticks present with stray bits", (tick_cnt > 0) ? 1 : 0, 1);

        // R5: disabled
        tag = "R5";
        write_ctrl({16'h8000, 16'h0002});
        repeat (300) @(negedge clk);
        check_eq("R5", "ticks while disabled", tick_cnt, 0);

        // R6: zero step
        tag = "R6";
        write_ctrl({16'h0000, 16'h0001});
        repeat (300) @(negedge clk);
        check_eq("R6", "ticks with zero step", tick_cnt, 0);

        // R7: restart mid-stream, first tick exactly 32 adds later
        tag = "R7";
        write_ctrl({16'h8000, 16'h0001});
        repeat (20) @(negedge clk);
        write_ctrl({16'h8000, 16'h0001});
        repeat (31) @(negedge clk);
        check_eq("R7", "no tick before 32 adds", tick_cnt, 0);
        repeat (2) @(negedge clk);
        check_eq("R7", "tick after 32 adds", tick_cnt, 1);

        // R7: new step applies at once (0x4000 -> 64 adds)
        write_ctrl({16'h4000, 16'h0001});
        repeat (63) @(negedge clk);
        check_eq("R7", "no tick before 64 adds", tick_cnt, 0);
        repeat (2) @(negedge clk);
        check_eq("R7", "tick after 64 adds", tick_cnt, 1);

        // R3: back-to-back writes then run
        tag = "R3";
        write_ctrl({16'hFFF0, 16'h0001});
        write_ctrl({16'hFFFF, 16'h0001});
        repeat (500) @(negedge clk);
        check_eq("R3", "ticks after double write", (tick_cnt >= 30) ? 1 : 0, 1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule